// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit

This block is a purely combinational integer unit. It takes two operands of a parameterised width (32 bits by default) and a 3-bit operation selector. It returns a result word and three flags: a zero indication, signed overflow and adder carry-out. The unit provides bitwise AND, bitwise OR, addition, subtraction and a signed set-if-less-than. A datapath can use it to form load and store addresses, to compare operands for conditional branches, and to execute register-to-register arithmetic.

There is no carry-in pin. The most significant selector bit requests the subtract path. When that bit is set, the second operand is complemented and a carry of one is injected into the adder, so the adder forms A + ~B + 1. Set-if-less-than reuses that difference. It corrects the sign of the difference with the overflow bit, so the comparison stays valid when the subtraction wraps. Selector values outside the five defined codes give an all-zero output. The adder can be built either as an explicit ripple chain or as a single behavioural sum.

Top module: `int_alu`

## Requirements
- R1: Selector 3'b000 drives the result with the bitwise AND of the two operands.
- R2: Selector 3'b001 drives the result with the bitwise OR of the two operands.
- R3: Selector 3'b010 drives the result with A + B modulo 2^W.
- R4: Selector 3'b110 drives the result with A - B modulo 2^W, formed as A + ~B + 1.
- R5: Selector 3'b111 drives the result with 1 when A is less than B as two's-complement signed numbers, and 0 otherwise. This holds when A - B overflows, and all upper result bits are 0.
- R6: For the five defined selectors, the zero flag is 1 exactly when the result is all zeros.
- R7: For add and subtract, overflow is 1 exactly when the two adder inputs (A and B after any inversion) share a sign and the sum's sign differs from it.
- R8: For add and subtract, carry-out is the carry leaving the top bit of the adder after any inversion of B. For subtract this means it is 1 when A >= B unsigned.
- R9: For AND, OR and set-if-less-than, overflow and carry-out are both 0.
- R10: Selectors 3'b011, 3'b100 and 3'b101 give a zero result, with the zero, overflow and carry-out flags all 0.
- R11: Every output depends only on the present inputs. The unit holds no state and adds no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a_i | input | W | First operand |
| opnd_b_i | input | W | Second operand |
| op_sel_i | input | 3 | Operation selector |
| result_o | output | W | Operation result |
| zero_o | output | 1 | Result is all zeros (defined selectors only) |
| ovf_o | output | 1 | Signed overflow of add or subtract |
| cout_o | output | 1 | Carry leaving the adder's top bit |

## Verification
Each result is due in the same cycle as the stimulus that produces it, because the unit has no registers. The bench drives operands and selector just after a rising clock edge and samples all four outputs at the following falling edge, half a period later. A reference model computes the expected word and flags arithmetically from the requirement text. The default 32-bit unit with the behavioural adder is swept over a grid of boundary operands and random operands. A 4-bit instance with the ripple adder is swept over every operand pair and every selector value.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int OP_W = 3;

    // Selector bit 2 requests the inverted-B, carry-in-one adder path.
    typedef enum logic [OP_W-1:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         inv_b_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         ovf_o
);

    logic [W-1:0] b_eff;
    logic         cin;

    assign b_eff = inv_b_i ? ~b_i : b_i;
    assign cin   = inv_b_i;

    generate
        if (RIPPLE) begin : g_ripple
            logic [W:0] chain;
            assign chain[0] = cin;
            for (genvar i = 0; i < W; i++) begin : g_bit
                assign sum_o[i]     = a_i[i] ^ b_eff[i] ^ chain[i];
                assign chain[i+1]   = (a_i[i] & b_eff[i]) | (chain[i] & (a_i[i] ^ b_eff[i]));
            end
            assign carry_o = chain[W];
        end else begin : g_flat
            logic [W:0] wide;
            assign wide    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin};
            assign sum_o   = wide[W-1:0];
            assign carry_o = wide[W];
        end
    endgenerate

    // Signed overflow: like-signed adder inputs, sum sign flipped.
    assign ovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);

endmodule

// File: rtl/int_alu_bitwise.sv
module int_alu_bitwise #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sel_or_i,
    output logic [W-1:0] out_o
);

    assign out_o = sel_or_i ? (a_i | b_i) : (a_i & b_i);

endmodule

// File: rtl/int_alu_outsel.sv
module int_alu_outsel
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    logic_i,
    input  logic [W-1:0]    sum_i,
    input  logic            carry_i,
    input  logic            ovf_i,
    output logic [W-1:0]    result_o,
    output logic            zero_o,
    output logic            ovf_o,
    output logic            cout_o
);

    logic less;

    // Sign of the difference corrected by overflow gives the signed order.
    assign less = sum_i[W-1] ^ ovf_i;

    always_comb begin
        result_o = '0;
        zero_o   = 1'b0;
        ovf_o    = 1'b0;
        cout_o   = 1'b0;
        unique case (op_i)
            ALU_AND, ALU_OR: begin
                result_o = logic_i;
                zero_o   = (logic_i == '0);
            end
            ALU_ADD, ALU_SUB: begin
                result_o = sum_i;
                zero_o   = (sum_i == '0);
                ovf_o    = ovf_i;
                cout_o   = carry_i;
            end
            ALU_SLT: begin
                result_o = {{(W-1){1'b0}}, less};
                zero_o   = ~less;
            end
            default: begin
                result_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  logic [W-1:0]    opnd_a_i,
    input  logic [W-1:0]    opnd_b_i,
    input  logic [OP_W-1:0] op_sel_i,
    output logic [W-1:0]    result_o,
    output logic            zero_o,
    output logic            ovf_o,
    output logic            cout_o
);

    logic [W-1:0] logic_w;
    logic [W-1:0] sum_w;
    logic         carry_w;
    logic         ovf_w;

    int_alu_bitwise #(.W(W)) u_bitwise (
        .a_i      (opnd_a_i),
        .b_i      (opnd_b_i),
        .sel_or_i (op_sel_i[0]),
        .out_o    (logic_w)
    );

    int_alu_addsub #(.W(W), .RIPPLE(RIPPLE)) u_addsub (
        .a_i     (opnd_a_i),
        .b_i     (opnd_b_i),
        .inv_b_i (op_sel_i[OP_W-1]),
        .sum_o   (sum_w),
        .carry_o (carry_w),
        .ovf_o   (ovf_w)
    );

    int_alu_outsel #(.W(W)) u_outsel (
        .op_i     (op_sel_i),
        .logic_i  (logic_w),
        .sum_i    (sum_w),
        .carry_i  (carry_w),
        .ovf_i    (ovf_w),
        .result_o (result_o),
        .zero_o   (zero_o),
        .ovf_o    (ovf_o),
        .cout_o   (cout_o)
    );

    // Port-level checks on the assembled outputs.
    always_comb begin
        if (op_sel_i == ALU_AND || op_sel_i == ALU_OR || op_sel_i == ALU_ADD ||
            op_sel_i == ALU_SUB || op_sel_i == ALU_SLT) begin
            assert_zero_flag_R6: assert (zero_o == (result_o == '0));
        end
        if (op_sel_i == ALU_SLT) begin
            assert_slt_narrow_R5: assert (result_o[W-1:1] == '0);
        end
        if (op_sel_i == ALU_AND || op_sel_i == ALU_OR || op_sel_i == ALU_SLT) begin
            assert_no_overflow_R9: assert (!ovf_o && !cout_o);
        end
        if (op_sel_i == ALU_ADD && ovf_o) begin
            assert_add_ovf_sign_R7: assert ((opnd_a_i[W-1] == opnd_b_i[W-1]) &&
                                            (result_o[W-1] != opnd_a_i[W-1]));
        end
        if (op_sel_i == 3'b011 || op_sel_i == 3'b100 || op_sel_i == 3'b101) begin
            assert_unused_clear_R10: assert (result_o == '0 && !zero_o && !ovf_o && !cout_o);
        end
    end

endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;  // 50 MHz

    logic [31:0] a, b, r;
    logic [2:0]  op;
    logic        z, v, c;

    logic [3:0]  sa, sb, sr;
    logic [2:0]  sop;
    logic        sz, sv, sc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int_alu #(.W(32), .RIPPLE(1'b0)) dut_i (
        .opnd_a_i(a), .opnd_b_i(b), .op_sel_i(op),
        .result_o(r), .zero_o(z), .ovf_o(v), .cout_o(c)
    );

    int_alu #(.W(4), .RIPPLE(1'b1)) dut_small (
        .opnd_a_i(sa), .opnd_b_i(sb), .op_sel_i(sop),
        .result_o(sr), .zero_o(sz), .ovf_o(sv), .cout_o(sc)
    );

    typedef struct {
        longint res;
        bit     z;
        bit     v;
        bit     c;
    } exp_t;

    function automatic exp_t model(longint xa, longint xb, int xop, int w);
        exp_t   e;
        longint mask, msb, bb, full, sxa, sxb;
        mask = (longint'(1) << w) - 1;
        msb  = longint'(1) << (w - 1);
        e.res = 0; e.z = 0; e.v = 0; e.c = 0;
        case (xop)
            0: e.res = xa & xb;
            1: e.res = xa | xb;
            2, 6: begin
                bb    = (xop == 2) ? xb : ((~xb) & mask);
                full  = xa + bb + ((xop == 2) ? 0 : 1);
                e.res = full & mask;
                e.c   = ((full >> w) & 1) != 0;
                e.v   = (((xa & msb) != 0) == ((bb & msb) != 0)) &&
                        (((e.res & msb) != 0) != ((xa & msb) != 0));
            end
            7: begin
                sxa   = ((xa & msb) != 0) ? xa - (mask + 1) : xa;
                sxb   = ((xb & msb) != 0) ? xb - (mask + 1) : xb;
                e.res = (sxa < sxb) ? 1 : 0;
            end
            default: e.res = 0;
        endcase
        if (xop == 0 || xop == 1 || xop == 2 || xop == 6 || xop == 7)
            e.z = (e.res == 0);
        return e;
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string res_tag(int xop);
        case (xop)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            6: return "R4";
            7: return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic check_vec(longint xa, longint xb, int xop, int w,
                             longint ar, bit az, bit av, bit ac);
        exp_t  e;
        bit    arith;
        string ft;
        e     = model(xa, xb, xop, w);
        arith = (xop == 2 || xop == 6);
        ft    = (xop == 3 || xop == 4 || xop == 5) ? "R10" : "R9";
        chk(res_tag(xop), "result", ar, e.res);
        chk((ft == "R10") ? "R10" : "R6", "zero", longint'(az), longint'(e.z));
        chk(arith ? "R7" : ft, "overflow", longint'(av), longint'(e.v));
        chk(arith ? "R8" : ft, "carry", longint'(ac), longint'(e.c));
    endtask

    function automatic logic [31:0] corner(int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'h8000_0001;
            6: return 32'h7FFF_FFFE;
            default: return 32'h5555_AAAA;
        endcase
    endfunction

    task automatic apply_big(logic [31:0] xa, logic [31:0] xb, logic [2:0] xop);
        @(posedge clk);
        a = xa; b = xb; op = xop;
        @(negedge clk);
        check_vec(longint'(xa), longint'(xb), int'(xop), 32,
                  longint'(r), z, v, c);
    endtask

    initial begin
        a = '0; b = '0; op = 3'b000;
        sa = '0; sb = '0; sop = 3'b000;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle state: zero operands with AND give zero result, zero flag set
        @(negedge clk);
        chk("R1", "idle result", longint'(r), 0);
        chk("R6", "idle zero", longint'(z), 1);

        // R11: output follows a fresh input within the same cycle
        @(posedge clk);
        a = 32'd40; b = 32'd2; op = 3'b010;
        #1;
        chk("R11", "same-cycle sum", longint'(r), 42);

        // Directed: subtraction overflow must not corrupt the signed compare (R5)
        apply_big(32'h8000_0000, 32'h0000_0001, 3'b111);
        apply_big(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
        apply_big(32'h8000_0000, 32'h0000_0001, 3'b110);
        apply_big(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);

        // Boundary grid, every selector
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                for (int k = 0; k < 8; k++)
                    apply_big(corner(i), corner(j), 3'(k));

        // Random operands
        for (int n = 0; n < 600; n++)
            for (int k = 0; k < 8; k++)
                apply_big($urandom(), $urandom(), 3'(k));

        // Exhaustive 4-bit ripple instance
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                for (int k = 0; k < 8; k++) begin
                    @(posedge clk);
                    sa = 4'(i); sb = 4'(j); sop = 3'(k);
                    @(negedge clk);
                    check_vec(longint'(i), longint'(j), k, 4,
                              longint'(sr), sz, sv, sc);
                end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule